// File: doc/BRIEF.md
# Compare-Timed Gate with Split-Counter Capture

The block builds a periodic gate from a free-running base-clock counter. It uses output compare. A compare register holds the base count at which the gate next changes level. On each match the gate flips, and the compare value moves forward by the length of the level just entered. The high length is a fixed fraction of the nominal base frequency, set by `HIGH_PCT`, which is 20 % by default. The low length is the rest of one second of base counts, so one full gate period lasts exactly `BASE_HZ` base cycles.

Each rising gate edge takes a snapshot of a measurement counter that runs on the unknown input clock `meas_clk`. This counter is split into a 16-bit low half and a 16-bit high half. The low half counts input edges, and the high half steps each time the low half wraps. A third 16-bit field counts wraps of the high half.

The gate edge is synchronized into the input-clock domain, and the snapshot is taken there. The record is then handed back to the base-clock domain with a toggle. It appears on a valid/ready output stream together with a 16-bit capture sequence number.

Back-pressure rule: a record stays on the outputs, unchanged and with valid high, until the consumer asserts ready. The stream has no queue. A capture that completes while an earlier record is still waiting is discarded, and its sequence number is consumed. The consumer can therefore see gaps in the sequence.

Top module: `freq_gate_capture`

## Requirements
- R1: The gate stays high for exactly HIGH = BASE_HZ*HIGH_PCT/100 base clock cycles per period (10,000,000 at the 50 MHz default).
- R2: After every high interval, the gate stays low for exactly LOW = BASE_HZ - HIGH base cycles, so the period equals BASE_HZ cycles.
- R3: While reset is asserted, gate_o and cap_valid_o are 0. After release, the first compare sits LOW counts past the counter's start value, so the gate first goes high on base clock edge LOW+1 after release.
- R4: The 32-bit base counter and the compare value wrap modulo 2^32, and gate timing is unaffected when the counter wraps.
- R5: cap_count_o = (high half << 16) | low half of the measurement counter. Its value is MEAS_START plus the meas_clk rising edges since reset, sampled two to four input edges after the gate's rising edge. The high half steps when the low half passes 0xFFFF.
- R6: cap_ovf_o carries the number of times the high half has wrapped from 0xFFFF to 0, taken in the same snapshot as cap_count_o.
- R7: cap_seq_o numbers the captures from 0 after reset and steps by one on every rising gate edge, including captures that are discarded. It is 16 bits wide.
- R8: While cap_valid_o is 1 and cap_ready_i is 0, the record holds stable. A capture that arrives in that time is discarded. A record is accepted on a clock edge where cap_valid_o and cap_ready_i are both 1.
- R9: Asserting reset in the middle of a run restarts the gate timing, the measurement counter and the sequence number from their start values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; times the gate and the output stream |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| meas_clk | input | 1 | Unknown input clock being counted |
| cap_ready_i | input | 1 | Consumer ready for the capture stream |
| gate_o | output | 1 | Gate signal, high for HIGH and low for LOW base cycles |
| cap_valid_o | output | 1 | A capture record is present |
| cap_count_o | output | 32 | Captured measurement count, high half over low half |
| cap_ovf_o | output | 16 | Wraps of the high half at capture time |
| cap_seq_o | output | 16 | Capture sequence number |

## Verification
The assertions check every base cycle that no high interval exceeds HIGH and that each high and each low interval ends at exactly its nominal length. They also check that a waiting record never changes, that an accepted record is replaced or dropped on the next cycle, and that reset holds the gate and valid low. Only the bench scenarios can show that the captured count agrees with an independent tally of input edges. The same applies to the carry into the high half and the overflow field, the sequence gaps left by discarded captures, and the full restart after a reset in mid-run.

// File: rtl/gate_cap_pkg.sv
package gate_cap_pkg;
  localparam int SEG_W = 16;
  localparam int NSEG  = 2;
  localparam int CNT_W = SEG_W * NSEG;

  typedef struct packed {
    logic [SEG_W-1:0] ovf;
    logic [SEG_W-1:0] seq;
    logic [CNT_W-1:0] count;
  } cap_rec_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/gate_compare_gen.sv
module gate_compare_gen #(
  parameter int                CMP_W      = 32,
  parameter logic [CMP_W-1:0]  HIGH_TICKS = 32'd10_000_000,
  parameter logic [CMP_W-1:0]  LOW_TICKS  = 32'd40_000_000,
  parameter logic [CMP_W-1:0]  BASE_START = '0
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_o
);
  logic [CMP_W-1:0] base_cnt_q;
  logic [CMP_W-1:0] cmp_q;
  logic             hit;
  logic [CMP_W-1:0] step;

  assign hit  = (base_cnt_q == cmp_q);
  // distance to the next match equals the length of the level being entered
  assign step = gate_o ? LOW_TICKS : HIGH_TICKS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_cnt_q <= BASE_START;
      cmp_q      <= BASE_START + LOW_TICKS;
      gate_o     <= 1'b0;
    end else begin
      base_cnt_q <= base_cnt_q + 1'b1;
      if (hit) begin
        cmp_q  <= cmp_q + step;
        gate_o <= ~gate_o;
      end
    end
  end
endmodule

// File: rtl/split_event_counter.sv
module split_event_counter #(
  parameter int                      SEG_W = 16,
  parameter int                      NSEG  = 2,
  parameter logic [SEG_W*NSEG-1:0]   START = '0
) (
  input  logic                   meas_clk,
  input  logic                   rst_n,
  output logic [SEG_W*NSEG-1:0]  value_o,
  output logic [SEG_W-1:0]       wraps_o
);
  logic [NSEG:0] carry;
  assign carry[0] = 1'b1;

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_seg
      logic [SEG_W-1:0] seg_q;
      always_ff @(posedge meas_clk or negedge rst_n) begin
        if (!rst_n)        seg_q <= START[g*SEG_W +: SEG_W];
        else if (carry[g]) seg_q <= seg_q + 1'b1;
      end
      assign carry[g+1]               = carry[g] & (&seg_q);
      assign value_o[g*SEG_W +: SEG_W] = seg_q;
    end
  endgenerate

  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n)          wraps_o <= '0;
    else if (carry[NSEG]) wraps_o <= wraps_o + 1'b1;
  end
endmodule

// File: rtl/gate_snapshot_xfer.sv
module gate_snapshot_xfer
  import gate_cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             meas_clk,
  input  logic             rst_n,
  input  logic             gate_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEG_W-1:0] wraps_i,
  input  logic             rec_ready_i,
  output logic             rec_valid_o,
  output cap_rec_t         rec_o
);
  // input-clock side: synchronize gate, snapshot on its rising edge
  logic             gate_m;
  logic             gate_m_d;
  logic             rise_m;
  logic             tgl_m;
  logic [SEG_W-1:0] seq_q;
  cap_rec_t         snap_q;

  bit_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(meas_clk), .rst_n(rst_n), .d_i(gate_i), .q_o(gate_m)
  );

  assign rise_m = gate_m & ~gate_m_d;

  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_m_d <= 1'b0;
      tgl_m    <= 1'b0;
      seq_q    <= '0;
      snap_q   <= '0;
    end else begin
      gate_m_d <= gate_m;
      if (rise_m) begin
        snap_q.count <= cnt_i;
        snap_q.ovf   <= wraps_i;
        snap_q.seq   <= seq_q;
        seq_q        <= seq_q + 1'b1;
        tgl_m        <= ~tgl_m;
      end
    end
  end

  // base-clock side: a toggle change marks a stable snapshot
  logic tgl_c;
  logic tgl_c_d;
  logic arrive;

  bit_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(tgl_m), .q_o(tgl_c)
  );

  assign arrive = tgl_c ^ tgl_c_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_c_d     <= 1'b0;
      rec_valid_o <= 1'b0;
      rec_o       <= '0;
    end else begin
      tgl_c_d <= tgl_c;
      if (arrive && (!rec_valid_o || rec_ready_i)) begin
        rec_o       <= snap_q;
        rec_valid_o <= 1'b1;
      end else if (rec_ready_i) begin
        rec_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/freq_gate_capture.sv
module freq_gate_capture
  import gate_cap_pkg::*;
#(
  parameter int unsigned      BASE_HZ     = 50_000_000,
  parameter int unsigned      HIGH_PCT    = 20,
  parameter int               CMP_W       = 32,
  parameter logic [CMP_W-1:0] BASE_START  = '0,
  parameter logic [CNT_W-1:0] MEAS_START  = '0,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_clk,
  input  logic             cap_ready_i,
  output logic             gate_o,
  output logic             cap_valid_o,
  output logic [CNT_W-1:0] cap_count_o,
  output logic [SEG_W-1:0] cap_ovf_o,
  output logic [SEG_W-1:0] cap_seq_o
);
  localparam logic [63:0]      HIGH_FULL  = (64'(BASE_HZ) * 64'(HIGH_PCT)) / 64'd100;
  localparam logic [63:0]      LOW_FULL   = 64'(BASE_HZ) - HIGH_FULL;
  localparam logic [CMP_W-1:0] HIGH_TICKS = HIGH_FULL[CMP_W-1:0];
  localparam logic [CMP_W-1:0] LOW_TICKS  = LOW_FULL[CMP_W-1:0];

  logic [CNT_W-1:0] meas_value;
  logic [SEG_W-1:0] meas_wraps;
  cap_rec_t         rec;

  gate_compare_gen #(
    .CMP_W(CMP_W), .HIGH_TICKS(HIGH_TICKS), .LOW_TICKS(LOW_TICKS), .BASE_START(BASE_START)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .gate_o(gate_o)
  );

  split_event_counter #(
    .SEG_W(SEG_W), .NSEG(NSEG), .START(MEAS_START)
  ) u_meas (
    .meas_clk(meas_clk), .rst_n(rst_n), .value_o(meas_value), .wraps_o(meas_wraps)
  );

  gate_snapshot_xfer #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_xfer (
    .clk(clk), .meas_clk(meas_clk), .rst_n(rst_n), .gate_i(gate_o),
    .cnt_i(meas_value), .wraps_i(meas_wraps),
    .rec_ready_i(cap_ready_i), .rec_valid_o(cap_valid_o), .rec_o(rec)
  );

  assign cap_count_o = rec.count;
  assign cap_ovf_o   = rec.ovf;
  assign cap_seq_o   = rec.seq;
endmodule

// File: rtl/freq_gate_capture_chk.sv
module freq_gate_capture_chk
  import gate_cap_pkg::*;
#(
  parameter int               CMP_W      = 32,
  parameter logic [CMP_W-1:0] HIGH_TICKS = 32'd10_000_000,
  parameter logic [CMP_W-1:0] LOW_TICKS  = 32'd40_000_000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_ready_i,
  input logic             gate_o,
  input logic             cap_valid_o,
  input logic [CNT_W-1:0] cap_count_o,
  input logic [SEG_W-1:0] cap_ovf_o,
  input logic [SEG_W-1:0] cap_seq_o
);
  logic [CMP_W-1:0] hi_run;
  logic [CMP_W-1:0] lo_run;
  logic             seen_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run    <= '0;
      lo_run    <= '0;
      seen_high <= 1'b0;
    end else begin
      hi_run <= gate_o ? hi_run + 1'b1 : '0;
      lo_run <= gate_o ? '0 : lo_run + 1'b1;
      if (gate_o) seen_high <= 1'b1;
    end
  end

  p_high_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> hi_run < HIGH_TICKS);

  p_high_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> hi_run == HIGH_TICKS);

  p_low_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_o) && seen_high) |-> lo_run == LOW_TICKS);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid_o && !cap_ready_i) |=>
      (cap_valid_o && $stable(cap_count_o) && $stable(cap_seq_o) && $stable(cap_ovf_o)));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid_o && cap_ready_i) |=> (!cap_valid_o || !$stable(cap_seq_o)));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r3: assert (!gate_o && !cap_valid_o);
    end
  end
endmodule

bind freq_gate_capture freq_gate_capture_chk #(
  .CMP_W(CMP_W), .HIGH_TICKS(HIGH_TICKS), .LOW_TICKS(LOW_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_ready_i(cap_ready_i), .gate_o(gate_o),
  .cap_valid_o(cap_valid_o), .cap_count_o(cap_count_o), .cap_ovf_o(cap_ovf_o),
  .cap_seq_o(cap_seq_o)
);

// File: tb/freq_gate_capture_bench.sv
`timescale 1ns/1ps
module freq_gate_capture_bench;
  localparam int unsigned BHZ   = 100;
  localparam int unsigned HPCT  = 20;
  localparam int          HI    = 20;   // BHZ*HPCT/100
  localparam int          LO    = 80;   // BHZ - HI
  localparam logic [31:0] BSTART = 32'hFFFF_FFC0;
  localparam logic [31:0] MSTART = 32'hFFFF_FF00;

  typedef struct packed {
    logic [15:0] seq;
    logic        stall;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{16'd0, 1'b0}, '{16'd1, 1'b0}, '{16'd2, 1'b1}, '{16'd4, 1'b0},
    '{16'd5, 1'b1}, '{16'd7, 1'b0}, '{16'd8, 1'b0}, '{16'd9, 1'b0}
  };

  logic        clk = 1'b0;
  logic        meas_clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cap_ready_i = 1'b0;
  logic        gate_o;
  logic        cap_valid_o;
  logic [31:0] cap_count_o;
  logic [15:0] cap_ovf_o;
  logic [15:0] cap_seq_o;

  int n_checks = 0;
  int n_errs   = 0;

  always #2.5 clk = ~clk;
  initial begin
    #1.3;
    forever begin
      meas_clk = 1'b1; #3.5;
      meas_clk = 1'b0; #3.5;
    end
  end

  freq_gate_capture #(
    .BASE_HZ(BHZ), .HIGH_PCT(HPCT), .BASE_START(BSTART), .MEAS_START(MSTART)
  ) u_freq_gate_capture (
    .clk(clk), .rst_n(rst_n), .meas_clk(meas_clk), .cap_ready_i(cap_ready_i),
    .gate_o(gate_o), .cap_valid_o(cap_valid_o), .cap_count_o(cap_count_o),
    .cap_ovf_o(cap_ovf_o), .cap_seq_o(cap_seq_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // independent tally of input edges since reset
  longint meas_n = 0;
  always @(posedge meas_clk) begin
    if (!rst_n) meas_n = 0;
    else        meas_n = meas_n + 1;
  end

  // gate run-length monitor and rise recorder
  longint rise_n [0:31];
  int     rise_idx = 0;
  int     run_len = 0;
  bit     prev_g = 1'b0;
  bit     first_run = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0; prev_g = 1'b0; first_run = 1'b1; rise_idx = 0;
    end else if (gate_o != prev_g) begin
      if (prev_g) begin
        check(run_len == HI, "R1", "high run length", run_len, HI);
      end else begin
        if (first_run) begin
          check(run_len == LO, "R3", "edges to first rise minus one", run_len, LO);
          check(run_len == LO, "R4", "low run across base wrap", run_len, LO);
        end else begin
          check(run_len == LO, "R2", "low run length", run_len, LO);
        end
        first_run = 1'b0;
        if (rise_idx < 32) rise_n[rise_idx] = meas_n;
        rise_idx++;
      end
      run_len = 1;
      prev_g  = gate_o;
    end else begin
      run_len++;
    end
  end

  task automatic wait_valid();
    int guard = 0;
    while (!cap_valid_o && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic check_record(input logic [15:0] seq_exp, input string tag);
    longint unsigned full;
    logic [31:0] diff;
    logic [15:0] ovf_exp;
    check(cap_valid_o == 1'b1, "R8", "record present", cap_valid_o, 1);
    check(cap_seq_o == seq_exp, "R7", {"sequence ", tag}, cap_seq_o, seq_exp);
    full    = 64'(MSTART) + 64'(rise_n[cap_seq_o[4:0]]);
    diff    = cap_count_o - full[31:0];
    ovf_exp = full[47:32] + 16'(((full[31:0] + 64'd2) >> 32));
    check(diff <= 32'd4, "R5", {"count window ", tag}, cap_count_o, full[31:0]);
    check(cap_ovf_o == ovf_exp, "R6", {"high-half wraps ", tag}, cap_ovf_o, ovf_exp);
  endtask

  task automatic accept();
    @(negedge clk); cap_ready_i = 1'b1;
    @(negedge clk); cap_ready_i = 1'b0;
    check(cap_valid_o == 1'b0, "R8", "valid clears after accept", cap_valid_o, 0);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_errs++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [31:0] held_cnt;
    logic [15:0] held_seq;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(gate_o == 1'b0, "R3", "gate in reset", gate_o, 0);
    check(cap_valid_o == 1'b0, "R3", "valid in reset", cap_valid_o, 0);
    #1 rst_n = 1'b1;

    // table walk: expected sequence per received record, optional stall
    for (int i = 0; i < 8; i++) begin
      wait_valid();
      check_record(VEC[i].seq, $sformatf("vec %0d", i));
      if (VEC[i].stall) begin
        held_cnt = cap_count_o;
        held_seq = cap_seq_o;
        repeat (130) @(negedge clk);
        check(cap_valid_o && cap_seq_o == held_seq, "R8", "held seq under stall",
              cap_seq_o, held_seq);
        check(cap_count_o == held_cnt, "R8", "held count under stall",
              cap_count_o, held_cnt);
        repeat (20) @(negedge clk);
      end
      accept();
    end

    // mid-run reset restarts everything
    repeat (37) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(gate_o == 1'b0, "R9", "gate after mid-run reset", gate_o, 0);
    check(cap_valid_o == 1'b0, "R9", "valid after mid-run reset", cap_valid_o, 0);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    wait_valid();
    check(cap_seq_o == 16'd0, "R9", "sequence restarts", cap_seq_o, 0);
    check_record(16'd0, "after reset");
    accept();
    wait_valid();
    check_record(16'd1, "second after reset");
    accept();

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule